// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small set of hardware lock flags that two independent ports share, so that software running behind each port can claim and release shared resources without a race. Each flag has a single token. A port asks for the token by writing a 0 into the flag's data bit and gives it back by writing a 1. A read returns the flag's state as seen from the reading side: 0 when the reader holds the token, 1 otherwise. That one-bit value is copied onto every bit of the read data bus.

A port reaches the flags only when its flag-select input is low and its chip enable is high. Accesses on any other combination are memory cycles that belong to another block, and the bank ignores them. The low address bits pick the flag. A request that lands while the opposite port holds the token is remembered. When the holder releases, the token goes straight to the waiting side and is never free in between. A waiting side that writes 1 withdraws its request. When both ports ask for the same free flag in the same cycle, the left port wins and the right request waits. All state is clocked. Read data appears one cycle after the read access and holds until the next read on that port.

Top module: `hwsem_bank`

## Requirements
- R1: While `rst` is high and after it falls, every flag is free with no waiting request, and both read buses hold all ones until the first read.
- R2: A port accesses the bank only when its `*_sel_n` is 0 and its `*_en_n` is 1. A read or write with `*_sel_n` = 1 or with `*_en_n` = 0 changes no flag and leaves that port's read bus unchanged.
- R3: A read (`*_wr_n` = 1) loads the port's `*_rdata` on the next clock edge with its status bit copied into all DATA_W bits. The bit is 0 when the reading port holds the flag at `*_addr` and 1 otherwise. `*_rdata` holds between reads.
- R4: A write (`*_wr_n` = 0) with `*_wbit` = 0 to a free flag gives that port the token.
- R5: A write of 0 to a flag held by the other port leaves ownership unchanged, so the writer still reads 1, and records a waiting request for the writer.
- R6: When the holder writes 1 while the other port has a waiting request, the token moves to the waiting port in the same edge. That port then reads 0 and the former holder reads 1.
- R7: When the holder writes 1 and no request is waiting, the flag becomes free and both ports read 1.
- R8: A port with a waiting request that writes 1 cancels that request. A later release by the holder then leaves the flag free.
- R9: When both ports write 0 to the same free flag in one cycle, the left port gets the token and the right port's request waits.
- R10: A write of 1 from a port that neither holds the flag nor waits on it has no effect.
- R11: `*_addr` selects one of NUM_SEM independent flags. An access to one flag never changes another.
- R12: A read returns the state from before any write applied on the same clock edge, including a write from the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left flag-bank select, active low |
| l_en_n | input | 1 | Left chip enable; must be 1 for a flag access |
| l_wr_n | input | 1 | Left direction: 0 write, 1 read |
| l_addr | input | ADDR_W (3) | Left flag index |
| l_wbit | input | 1 | Left write bit: 0 request, 1 release |
| l_rdata | output | DATA_W (18) | Left registered status, replicated |
| r_sel_n | input | 1 | Right flag-bank select, active low |
| r_en_n | input | 1 | Right chip enable; must be 1 for a flag access |
| r_wr_n | input | 1 | Right direction: 0 write, 1 read |
| r_addr | input | ADDR_W (3) | Right flag index |
| r_wbit | input | 1 | Right write bit: 0 request, 1 release |
| r_rdata | output | DATA_W (18) | Right registered status, replicated |

## Verification
The checker watches several rules on every cycle. A waiting request only exists while the opposite port holds that flag. Read buses are always uniform. Cycles with no qualified write leave all flags untouched. Grabs of free flags, plain releases, direct hand-offs and the left-wins tie each land on the very next edge. The bench scenarios cover what a single-cycle property cannot reach: a cancelled request staying cancelled through a later release, the held read data when a read is disqualified, the pre-write value a same-edge read returns, and long random mixes of both ports checked against a reference model.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    owner_e owner;
    logic   wait_l;
    logic   wait_r;
  } sem_st_t;

  localparam sem_st_t SEM_RESET = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

  // One port's write applied to one flag.
  function automatic sem_st_t sem_apply(sem_st_t s, logic from_left, logic val);
    sem_st_t n;
    owner_e  self_o;
    owner_e  other_o;
    logic    self_wait;
    logic    other_wait;
    n          = s;
    self_o     = from_left ? OWN_LEFT : OWN_RIGHT;
    other_o    = from_left ? OWN_RIGHT : OWN_LEFT;
    self_wait  = from_left ? s.wait_l : s.wait_r;
    other_wait = from_left ? s.wait_r : s.wait_l;
    if (!val) begin
      if (s.owner == OWN_NONE) begin
        n.owner = self_o;
      end else if (s.owner == other_o) begin
        if (from_left) n.wait_l = 1'b1;
        else           n.wait_r = 1'b1;
      end
    end else begin
      if (s.owner == self_o) begin
        if (other_wait) begin
          n.owner = other_o;
          if (from_left) n.wait_r = 1'b0;
          else           n.wait_l = 1'b0;
        end else begin
          n.owner = OWN_NONE;
        end
      end else if (self_wait) begin
        if (from_left) n.wait_l = 1'b0;
        else           n.wait_r = 1'b0;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/hwsem_port_dec.sv
module hwsem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 3
) (
  input  logic               sel_n,
  input  logic               en_n,
  input  logic               wr_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wbit,
  output logic               rd_req,
  output logic [NUM_SEM-1:0] wr_hit,
  output logic               wr_val
);
  logic acc;
  logic wr_req;

  assign acc    = ~sel_n & en_n;
  assign rd_req = acc & wr_n;
  assign wr_req = acc & ~wr_n;
  assign wr_val = wbit;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
    assign wr_hit[i] = wr_req && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/hwsem_cell.sv
module hwsem_cell
  import hwsem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_wr,
  input  logic l_val,
  input  logic r_wr,
  input  logic r_val,
  output logic own_l,
  output logic own_r,
  output logic wait_l,
  output logic wait_r
);
  sem_st_t st_q;
  sem_st_t mid;
  sem_st_t nxt;

  // Left write resolves first, then right: gives the left-wins tie.
  always_comb begin
    mid = l_wr ? sem_apply(st_q, 1'b1, l_val) : st_q;
    nxt = r_wr ? sem_apply(mid, 1'b0, r_val) : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEM_RESET;
    else     st_q <= nxt;
  end

  assign own_l  = (st_q.owner == OWN_LEFT);
  assign own_r  = (st_q.owner == OWN_RIGHT);
  assign wait_l = st_q.wait_l;
  assign wait_r = st_q.wait_r;
endmodule

// File: rtl/hwsem_rd_port.sv
module hwsem_rd_port #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]  rdata
);
  logic sel_own;

  always_comb begin
    sel_own = 1'b0;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (addr == ADDR_W'(i)) sel_own = own_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '1;
    else if (rd_req) rdata <= {DATA_W{~sel_own}};
  end
endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel_n,
  input  logic              l_en_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel_n,
  input  logic              r_en_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  logic               l_rd, r_rd;
  logic               l_val, r_val;
  logic [NUM_SEM-1:0] l_hit, r_hit;
  logic [NUM_SEM-1:0] own_l_v, own_r_v, wait_l_v, wait_r_v;

  hwsem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_l (
    .sel_n(l_sel_n), .en_n(l_en_n), .wr_n(l_wr_n), .addr(l_addr), .wbit(l_wbit),
    .rd_req(l_rd), .wr_hit(l_hit), .wr_val(l_val)
  );

  hwsem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_r (
    .sel_n(r_sel_n), .en_n(r_en_n), .wr_n(r_wr_n), .addr(r_addr), .wbit(r_wbit),
    .rd_req(r_rd), .wr_hit(r_hit), .wr_val(r_val)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    hwsem_cell u_cell (
      .clk(clk), .rst(rst),
      .l_wr(l_hit[i]), .l_val(l_val),
      .r_wr(r_hit[i]), .r_val(r_val),
      .own_l(own_l_v[i]), .own_r(own_r_v[i]),
      .wait_l(wait_l_v[i]), .wait_r(wait_r_v[i])
    );
  end

  hwsem_rd_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_req(l_rd), .addr(l_addr), .own_vec(own_l_v), .rdata(l_rdata)
  );

  hwsem_rd_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_req(r_rd), .addr(r_addr), .own_vec(own_r_v), .rdata(r_rdata)
  );
endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               l_sel_n,
  input logic               l_en_n,
  input logic               l_wr_n,
  input logic [ADDR_W-1:0]  l_addr,
  input logic               l_wbit,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               r_sel_n,
  input logic               r_en_n,
  input logic               r_wr_n,
  input logic [ADDR_W-1:0]  r_addr,
  input logic               r_wbit,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] wait_l,
  input logic [NUM_SEM-1:0] wait_r
);
  logic lw, rw;
  assign lw = !l_sel_n && l_en_n && !l_wr_n;
  assign rw = !r_sel_n && r_en_n && !r_wr_n;

  assert_reset_free_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (own_l == '0 && own_r == '0 && wait_l == '0 && wait_r == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!lw && !rw) |=> ($stable(own_l) && $stable(own_r) && $stable(wait_l) && $stable(wait_r)));

  assert_rdata_uniform_R3: assert property (@(posedge clk) disable iff (rst)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  assert_grab_free_R4: assert property (@(posedge clk) disable iff (rst)
    (lw && !l_wbit && !own_l[l_addr] && !own_r[l_addr]) |=> own_l[$past(l_addr)]);

  assert_wait_needs_holder_R5: assert property (@(posedge clk) disable iff (rst)
    ((wait_l & ~own_r) == '0) && ((wait_r & ~own_l) == '0));

  assert_handoff_R6: assert property (@(posedge clk) disable iff (rst)
    (lw && l_wbit && own_l[l_addr] && wait_r[l_addr] && !(rw && r_addr == l_addr))
    |=> own_r[$past(l_addr)]);

  assert_release_free_R7: assert property (@(posedge clk) disable iff (rst)
    (lw && l_wbit && own_l[l_addr] && !wait_r[l_addr] && !(rw && r_addr == l_addr))
    |=> (!own_l[$past(l_addr)] && !own_r[$past(l_addr)]));

  assert_tie_left_R9: assert property (@(posedge clk) disable iff (rst)
    (lw && rw && !l_wbit && !r_wbit && l_addr == r_addr && !own_l[l_addr] && !own_r[l_addr])
    |=> (own_l[$past(l_addr)] && wait_r[$past(l_addr)]));
endmodule

bind hwsem_bank hwsem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sel_n(l_sel_n), .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
  .r_sel_n(r_sel_n), .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata),
  .own_l(own_l_v), .own_r(own_r_v), .wait_l(wait_l_v), .wait_r(wait_r_v)
);

// File: tb/hwsem_bank_bench.sv
module hwsem_bank_bench;
  localparam int NS = 8;
  localparam int DW = 18;
  localparam int AW = 3;

  // access kinds
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_WR_ENLOW = 3, K_WR_NOSEL = 4, K_RD_ENLOW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel_n = 1'b1, l_en_n = 1'b1, l_wr_n = 1'b1, l_wbit = 1'b1;
  logic r_sel_n = 1'b1, r_en_n = 1'b1, r_wr_n = 1'b1, r_wbit = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model: owner 0 free, 1 left, 2 right; waiting[side][flag]
  int m_own [NS];
  bit m_wait [3][NS];
  logic m_lrd = 1'b1, m_rrd = 1'b1;
  int kl = K_IDLE, kr = K_IDLE, al = 0, ar = 0;
  bit bl = 1'b1, br = 1'b1;

  always #10 clk = ~clk;

  hwsem_bank #(.NUM_SEM(NS), .DATA_W(DW)) u_hwsem_bank (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rep(input logic b);
    return {DW{b}};
  endfunction

  task automatic m_write(input int side, input int a, input bit b);
    int other = 3 - side;
    if (!b) begin
      if (m_own[a] == 0) m_own[a] = side;
      else if (m_own[a] == other) m_wait[side][a] = 1'b1;
    end else begin
      if (m_own[a] == side) begin
        if (m_wait[other][a]) begin m_own[a] = other; m_wait[other][a] = 1'b0; end
        else m_own[a] = 0;
      end else m_wait[side][a] = 1'b0;
    end
  endtask

  task automatic drive_l(input int k, input int a, input bit b);
    kl = k; al = a; bl = b;
    l_addr = AW'(a); l_wbit = b;
    l_sel_n = !(k == K_RD || k == K_WR || k == K_WR_ENLOW || k == K_RD_ENLOW);
    l_en_n  = !(k == K_WR_ENLOW || k == K_RD_ENLOW);
    l_wr_n  = !(k == K_WR || k == K_WR_ENLOW || k == K_WR_NOSEL);
  endtask

  task automatic drive_r(input int k, input int a, input bit b);
    kr = k; ar = a; br = b;
    r_addr = AW'(a); r_wbit = b;
    r_sel_n = !(k == K_RD || k == K_WR || k == K_WR_ENLOW || k == K_RD_ENLOW);
    r_en_n  = !(k == K_WR_ENLOW || k == K_RD_ENLOW);
    r_wr_n  = !(k == K_WR || k == K_WR_ENLOW || k == K_WR_NOSEL);
  endtask

  // one clock: model update, edge, sample at negedge, compare with model
  task automatic step();
    if (kl == K_RD) m_lrd = (m_own[al] == 1) ? 1'b0 : 1'b1;
    if (kr == K_RD) m_rrd = (m_own[ar] == 2) ? 1'b0 : 1'b1;
    if (kl == K_WR) m_write(1, al, bl);
    if (kr == K_WR) m_write(2, ar, br);
    @(posedge clk);
    @(negedge clk);
    chk("R3 left model", l_rdata, rep(m_lrd));
    chk("R3 right model", r_rdata, rep(m_rrd));
    drive_l(K_IDLE, 0, 1'b1);
    drive_r(K_IDLE, 0, 1'b1);
  endtask

  task automatic wl(input int a, input bit b); drive_l(K_WR, a, b); step(); endtask
  task automatic wr(input int a, input bit b); drive_r(K_WR, a, b); step(); endtask
  task automatic rl(input int a, input logic e, input string tag);
    drive_l(K_RD, a, 1'b1); step(); chk(tag, l_rdata, rep(e));
  endtask
  task automatic rr(input int a, input logic e, input string tag);
    drive_r(K_RD, a, 1'b1); step(); chk(tag, r_rdata, rep(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_own[i] = 0; m_wait[1][i] = 0; m_wait[2][i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 left rdata in reset", l_rdata, '1);
    chk("R1 right rdata in reset", r_rdata, '1);
    rst = 1'b0;
    step();
    chk("R1 left rdata after reset", l_rdata, '1);
    for (int i = 0; i < NS; i++) begin
      rl(i, 1'b1, "R1 left free after reset");
      rr(i, 1'b1, "R1 right free after reset");
    end

    // R4 R5 R6 R7 on flag 2
    wl(2, 1'b0);
    rl(2, 1'b0, "R4 left owns after grab");
    rr(2, 1'b1, "R4 right sees taken");
    wr(2, 1'b0);
    rr(2, 1'b1, "R5 right request no change");
    rl(2, 1'b0, "R5 left still owns");
    wl(2, 1'b1);
    rr(2, 1'b0, "R6 right receives token");
    rl(2, 1'b1, "R6 left gave up token");
    wr(2, 1'b1);
    rr(2, 1'b1, "R7 right free after release");
    rl(2, 1'b1, "R7 left free after release");

    // R8 withdraw on flag 5
    wl(5, 1'b0);
    wr(5, 1'b0);
    wr(5, 1'b1);
    wl(5, 1'b1);
    rr(5, 1'b1, "R8 withdrawn request not granted");
    rl(5, 1'b1, "R8 flag free");

    // R10 stray release
    wr(5, 1'b1);
    rl(5, 1'b1, "R10 left free after stray write");
    rr(5, 1'b1, "R10 right free after stray write");
    wl(6, 1'b0);
    wr(6, 1'b1);
    rl(6, 1'b0, "R10 holder keeps token");
    wl(6, 1'b1);
    rr(6, 1'b1, "R10 no hidden request");

    // R9 tie on flag 1
    drive_l(K_WR, 1, 1'b0); drive_r(K_WR, 1, 1'b0); step();
    rl(1, 1'b0, "R9 left wins tie");
    rr(1, 1'b1, "R9 right waits");
    wl(1, 1'b1);
    rr(1, 1'b0, "R9 waiting right granted");
    wr(1, 1'b1);

    // R2 disqualified accesses
    drive_l(K_WR_ENLOW, 3, 1'b0); step();
    rl(3, 1'b1, "R2 write with enable low ignored");
    drive_l(K_WR_NOSEL, 3, 1'b0); step();
    rl(3, 1'b1, "R2 write without select ignored");
    wl(3, 1'b0);
    rl(3, 1'b0, "R2 setup left owns 3");
    drive_l(K_RD_ENLOW, 4, 1'b1); step();
    chk("R2 read with enable low keeps rdata", l_rdata, rep(1'b0));

    // R11 independence: flag 3 held by left
    rl(4, 1'b1, "R11 left other flag free");
    wr(4, 1'b0);
    rr(4, 1'b0, "R11 right owns flag 4");
    rl(3, 1'b0, "R11 flag 3 untouched");
    wl(3, 1'b1);
    wr(4, 1'b1);

    // R12 same-edge read sees pre-write state
    wr(0, 1'b0);
    wl(0, 1'b0);
    drive_l(K_RD, 0, 1'b1); drive_r(K_WR, 0, 1'b1); step();
    chk("R12 left read before handoff", l_rdata, rep(1'b1));
    rl(0, 1'b0, "R12 left owns after handoff");
    wl(0, 1'b1);

    // random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      int narrow = $urandom_range(1, 0);
      int ka = $urandom_range(5, 0);
      int kb = $urandom_range(5, 0);
      int aa = narrow ? $urandom_range(1, 0) : $urandom_range(NS - 1, 0);
      int ab = narrow ? $urandom_range(1, 0) : $urandom_range(NS - 1, 0);
      if (ka > 3 && $urandom_range(1, 0) == 1) ka = K_WR;
      if (kb > 3 && $urandom_range(1, 0) == 1) kb = K_WR;
      drive_l(ka, aa, 1'($urandom_range(1, 0)));
      drive_r(kb, ab, 1'($urandom_range(1, 0)));
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd1234);
  end
endmodule